// File: doc/BRIEF.md
# Radio Frame Start-Pulse Generator

This block tracks where the receiver is inside a 10 ms radio frame. It keeps three nested counters: the word inside a basic frame, the basic frame inside a hyperframe, and the hyperframe inside the radio frame. Every accepted receive word advances the word counter. Each counter carries into the next one when it wraps. A radio-frame-boundary pulse sets all three counters back to the origin.

A 32-bit start-offset value names one coordinate inside the frame. When the word being received sits at that coordinate, the block raises a registered start pulse for one clock. Software can set the offset later than the position it actually wants, so that the pulse allows for the latency of the receive path and its buffers. The number of words in each basic frame is a parameter and stands in for the line rate. The basic-frame and hyperframe limits are also parameters, with defaults of 256 and 150.

Top module: `frame_start_gen`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, `start_o` is 0 and all three position outputs are 0.
- R2: Each cycle with `word_stb_i` high and `frame_sync_i` low moves `pos_word_o` up by one, and it returns from WORDS_PER_BF-1 to 0.
- R3: `pos_bf_o` moves up by one only on a strobe that wraps the word counter, and it returns from BF_PER_HF-1 to 0. Otherwise it holds.
- R4: `pos_hf_o` moves up by one on a strobe that wraps both lower counters, and it returns from HF_PER_FRAME-1 to 0. After one full frame of strobes the position is back at the origin.
- R5: A cycle with `frame_sync_i` high leaves all three counters at 0 on the next cycle. A strobe in that same cycle is neither counted nor matched, so it gives no pulse.
- R6: A cycle with neither strobe nor sync leaves the position unchanged and gives no pulse.
- R7: Offset layout: bits [31:24] give the hyperframe, bits [23:16] give the word, and bits [7:0] give the basic frame. Bits [15:8] have no effect.
- R8: `start_o` is 1 in the cycle after a counted strobe whose position before the advance equals all three offset fields. It is 1 for exactly one cycle, and only after a counted strobe.
- R9: With the default 16 words per basic frame, offset 0x00020001 fires on the 19th counted strobe after a sync. That strobe is word 2 of basic frame 1 of hyperframe 0.
- R10: The pulse fires at most once per frame. An offset whose word field or hyperframe field lies outside the counter range never fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| word_stb_i | input | 1 | One receive word accepted this cycle |
| frame_sync_i | input | 1 | Radio-frame boundary, clears the position |
| start_ofs_i | input | 32 | Packed start coordinate (hyperframe, word, basic frame) |
| start_o | output | 1 | Registered one-cycle start pulse |
| pos_word_o | output | clog2(WORDS_PER_BF) | Word index inside the current basic frame |
| pos_bf_o | output | clog2(BF_PER_HF) | Basic frame index inside the hyperframe |
| pos_hf_o | output | clog2(HF_PER_FRAME) | Hyperframe index inside the radio frame |

## Verification
On every cycle, the assertions check the step and range of the word counter and check that the basic-frame counter holds unless the word counter wraps. They also check the hyperframe range, the clearing by sync, the hold on idle cycles, and that every pulse is one cycle wide and follows a counted strobe. The directed scenarios are needed for the rest. They show that the pulse falls on exactly the programmed coordinate, including the documented example and a value with junk in the unused bits. They also show that the position returns to the origin after a whole frame, that the pulse repeats once per frame, and that an out-of-range offset stays silent. A second, small instance of the block makes full-frame wrapping reachable within the run.

// File: rtl/frame_pos_pkg.sv
package frame_pos_pkg;

    localparam int FIELD_W  = 8;
    localparam int OFS_W    = 32;
    localparam int HF_LSB   = 24;
    localparam int WORD_LSB = 16;
    localparam int BF_LSB   = 0;

    typedef struct packed {
        logic [FIELD_W-1:0] hf;
        logic [FIELD_W-1:0] word;
        logic [FIELD_W-1:0] bf;
    } start_coord_t;

    function automatic int idx_width(input int limit);
        return (limit > 1) ? $clog2(limit) : 1;
    endfunction

    function automatic start_coord_t unpack_offset(input logic [OFS_W-1:0] raw);
        start_coord_t c;
        c.hf   = raw[HF_LSB   +: FIELD_W];
        c.word = raw[WORD_LSB +: FIELD_W];
        c.bf   = raw[BF_LSB   +: FIELD_W];
        return c;
    endfunction

endpackage

// File: rtl/frame_pos_digit.sv
module frame_pos_digit #(
    parameter int LIMIT = 16,
    parameter int W     = 4
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] val_o,
    output logic         wrap_o
);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_nxt;

    generate
        if (LIMIT == (1 << W)) begin : g_pow2
            assign cnt_nxt = cnt_q + 1'b1;
        end else begin : g_cmp
            assign cnt_nxt = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_nxt;
        end
    end

    assign wrap_o = inc_i && (cnt_q == LAST);
    assign val_o  = cnt_q;
endmodule

// File: rtl/frame_start_match.sv
module frame_start_match
    import frame_pos_pkg::*;
#(
    parameter int WW = 4,
    parameter int BW = 8,
    parameter int HW = 8
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          count_en_i,
    input  logic [WW-1:0] word_i,
    input  logic [BW-1:0] bf_i,
    input  logic [HW-1:0] hf_i,
    input  start_coord_t  target_i,
    output logic          start_o
);
    logic at_target;
    logic start_q;

    assign at_target = (target_i.word == FIELD_W'(word_i))
                    && (target_i.bf   == FIELD_W'(bf_i))
                    && (target_i.hf   == FIELD_W'(hf_i));

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            start_q <= 1'b0;
        end else begin
            start_q <= count_en_i && at_target;
        end
    end

    assign start_o = start_q;
endmodule

// File: rtl/frame_start_gen.sv
module frame_start_gen
    import frame_pos_pkg::*;
#(
    parameter int WORDS_PER_BF = 16,
    parameter int BF_PER_HF    = 256,
    parameter int HF_PER_FRAME = 150,
    localparam int WW = idx_width(WORDS_PER_BF),
    localparam int BW = idx_width(BF_PER_HF),
    localparam int HW = idx_width(HF_PER_FRAME)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          word_stb_i,
    input  logic          frame_sync_i,
    input  logic [31:0]   start_ofs_i,
    output logic          start_o,
    output logic [WW-1:0] pos_word_o,
    output logic [BW-1:0] pos_bf_o,
    output logic [HW-1:0] pos_hf_o
);
    start_coord_t target;
    logic         count_en;
    logic         word_wrap;
    logic         bf_wrap;
    logic         hf_wrap;

    assign target   = unpack_offset(start_ofs_i);
    assign count_en = word_stb_i && !frame_sync_i;

    frame_pos_digit #(.LIMIT(WORDS_PER_BF), .W(WW)) u_word (
        .clk_i (clk_i), .rst_i (rst_i), .clr_i (frame_sync_i),
        .inc_i (count_en), .val_o (pos_word_o), .wrap_o (word_wrap)
    );

    frame_pos_digit #(.LIMIT(BF_PER_HF), .W(BW)) u_bf (
        .clk_i (clk_i), .rst_i (rst_i), .clr_i (frame_sync_i),
        .inc_i (word_wrap), .val_o (pos_bf_o), .wrap_o (bf_wrap)
    );

    frame_pos_digit #(.LIMIT(HF_PER_FRAME), .W(HW)) u_hf (
        .clk_i (clk_i), .rst_i (rst_i), .clr_i (frame_sync_i),
        .inc_i (bf_wrap), .val_o (pos_hf_o), .wrap_o (hf_wrap)
    );

    frame_start_match #(.WW(WW), .BW(BW), .HW(HW)) u_match (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .count_en_i (count_en),
        .word_i     (pos_word_o),
        .bf_i       (pos_bf_o),
        .hf_i       (pos_hf_o),
        .target_i   (target),
        .start_o    (start_o)
    );

    logic unused_ok;
    assign unused_ok = ^{hf_wrap, start_ofs_i[15:8]};
endmodule

// File: rtl/frame_start_gen_chk.sv
module frame_start_gen_chk
    import frame_pos_pkg::*;
#(
    parameter int WORDS_PER_BF = 16,
    parameter int BF_PER_HF    = 256,
    parameter int HF_PER_FRAME = 150,
    localparam int WW = idx_width(WORDS_PER_BF),
    localparam int BW = idx_width(BF_PER_HF),
    localparam int HW = idx_width(HF_PER_FRAME)
) (
    input logic          clk_i,
    input logic          rst_i,
    input logic          stb_i,
    input logic          sync_i,
    input logic          start_i,
    input logic [WW-1:0] word_i,
    input logic [BW-1:0] bf_i,
    input logic [HW-1:0] hf_i
);
    localparam logic [WW-1:0] WORD_LAST = WW'(WORDS_PER_BF - 1);
    localparam logic [HW-1:0] HF_LAST   = HW'(HF_PER_FRAME - 1);

    logic adv;
    assign adv = stb_i && !sync_i;

    p_word_step_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (adv && word_i != WORD_LAST) |=> (word_i == $past(word_i) + 1'b1));

    p_word_range_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        word_i <= WORD_LAST);

    p_bf_hold_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (adv && word_i != WORD_LAST) |=> $stable(bf_i));

    p_hf_range_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        hf_i <= HF_LAST);

    p_sync_clear_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        sync_i |=> (word_i == '0 && bf_i == '0 && hf_i == '0 && !start_i));

    p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (!stb_i && !sync_i) |=> ($stable(word_i) && $stable(bf_i) && $stable(hf_i) && !start_i));

    p_single_pulse_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        start_i |=> !start_i);

    p_pulse_cause_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        start_i |-> $past(adv));
endmodule

bind frame_start_gen frame_start_gen_chk #(
    .WORDS_PER_BF (WORDS_PER_BF),
    .BF_PER_HF    (BF_PER_HF),
    .HF_PER_FRAME (HF_PER_FRAME)
) u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .stb_i   (word_stb_i),
    .sync_i  (frame_sync_i),
    .start_i (start_o),
    .word_i  (pos_word_o),
    .bf_i    (pos_bf_o),
    .hf_i    (pos_hf_o)
);

// File: tb/test_frame_start_gen.sv
module test_frame_start_gen;
    localparam int CLK_PERIOD = 10;

    localparam int WB = 16, BB = 256, HB = 150;
    localparam int WS = 4,  BS = 8,   HS = 5;
    localparam int FRAME_B = WB * BB * HB;
    localparam int FRAME_S = WS * BS * HS;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stb = 1'b0;
    logic        fsync = 1'b0;
    logic [31:0] ofs_b = 32'h0;
    logic [31:0] ofs_s = 32'h0;

    logic       start_b, start_s;
    logic [3:0] word_b;
    logic [7:0] bf_b, hf_b;
    logic [1:0] word_s;
    logic [2:0] bf_s, hf_s;

    int n_checks = 0;
    int n_fail   = 0;
    int idx_b = 0, idx_s = 0;
    int cnt_b = 0, cnt_s = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frame_start_gen i_frame_start_gen (
        .clk_i (clk), .rst_i (rst), .word_stb_i (stb), .frame_sync_i (fsync),
        .start_ofs_i (ofs_b), .start_o (start_b),
        .pos_word_o (word_b), .pos_bf_o (bf_b), .pos_hf_o (hf_b)
    );

    frame_start_gen #(.WORDS_PER_BF(WS), .BF_PER_HF(BS), .HF_PER_FRAME(HS)) i_frame_start_gen_small (
        .clk_i (clk), .rst_i (rst), .word_stb_i (stb), .frame_sync_i (fsync),
        .start_ofs_i (ofs_s), .start_o (start_s),
        .pos_word_o (word_s), .pos_bf_o (bf_s), .pos_hf_o (hf_s)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // offset layout per R7: hf [31:24], word [23:16], bf [7:0]
    function automatic bit hit(input logic [31:0] o, input int idx, input int w, input int b, input int h);
        return (int'(o[23:16]) == idx % w) && (int'(o[7:0]) == (idx / w) % b)
            && (int'(o[31:24]) == (idx / (w * b)) % h);
    endfunction

    // one cycle of stimulus; called at a falling edge, returns at the next
    task automatic tick(input logic s, input logic y, input string tag);
        bit eb, es;
        eb = s && !y && hit(ofs_b, idx_b, WB, BB, HB);
        es = s && !y && hit(ofs_s, idx_s, WS, BS, HS);
        stb = s; fsync = y;
        @(negedge clk);
        if (y) begin
            idx_b = 0; idx_s = 0;
        end else if (s) begin
            idx_b = (idx_b + 1) % FRAME_B;
            idx_s = (idx_s + 1) % FRAME_S;
        end
        chk(tag, int'(word_b), idx_b % WB);
        chk(tag, int'(bf_b), (idx_b / WB) % BB);
        chk(tag, int'(hf_b), idx_b / (WB * BB));
        chk(tag, int'(word_s), idx_s % WS);
        chk(tag, int'(bf_s), (idx_s / WS) % BS);
        chk(tag, int'(hf_s), idx_s / (WS * BS));
        chk("R8 big pulse", int'(start_b), int'(eb));
        chk("R8 small pulse", int'(start_s), int'(es));
        if (start_b) cnt_b++;
        if (start_s) cnt_s++;
    endtask

    task automatic t_reset();
        chk("R1 start", int'(start_b) + int'(start_s), 0);
        chk("R1 pos big", int'(word_b) + int'(bf_b) + int'(hf_b), 0);
        chk("R1 pos small", int'(word_s) + int'(bf_s) + int'(hf_s), 0);
    endtask

    task automatic t_count();
        ofs_b = 32'h0005_0003;
        ofs_s = 32'h0005_0000;
        tick(1'b0, 1'b1, "R5");
        for (int i = 0; i < 40; i++) begin
            tick(1'b1, 1'b0, "R2");
            if (i % 3 == 0) tick(1'b0, 1'b0, "R6");
        end
        chk("R3 small bf after carries", int'(bf_s), 2);
        chk("R4 small hf after carry", int'(hf_s), 1);
    endtask

    task automatic t_example();
        ofs_b = 32'h0002_0001;
        tick(1'b0, 1'b1, "R5");
        cnt_b = 0;
        for (int i = 0; i < 30; i++) begin
            tick(1'b1, 1'b0, "R2");
            if (i == 18) chk("R9 pulse on 19th strobe", int'(start_b), 1);
        end
        chk("R9 pulse count", cnt_b, 1);
    endtask

    task automatic t_ignore_bits();
        ofs_b = 32'h0002_C301;
        tick(1'b0, 1'b1, "R5");
        cnt_b = 0;
        for (int i = 0; i < 25; i++) begin
            tick(1'b1, 1'b0, "R7");
            if (i == 18) chk("R7 pulse with junk bits", int'(start_b), 1);
        end
        chk("R7 pulse count", cnt_b, 1);
    endtask

    task automatic t_full_frame();
        ofs_s = 32'h0403_0007;
        tick(1'b0, 1'b1, "R5");
        cnt_s = 0;
        for (int i = 0; i < 2 * FRAME_S; i++) begin
            tick(1'b1, 1'b0, "R4");
            if (i == FRAME_S - 1) begin
                chk("R4 origin after frame", int'(word_s) + int'(bf_s) + int'(hf_s), 0);
                chk("R10 pulse at last word", int'(start_s), 1);
            end
        end
        chk("R10 one pulse per frame", cnt_s, 2);
    endtask

    task automatic t_sync_priority();
        ofs_s = 32'h0000_0000;
        tick(1'b0, 1'b1, "R5");
        tick(1'b1, 1'b0, "R8");
        tick(1'b1, 1'b0, "R2");
        tick(1'b1, 1'b1, "R5");
        chk("R5 strobe with sync gives no pulse", int'(start_s), 0);
        chk("R5 strobe with sync not counted", int'(word_s), 0);
        tick(1'b1, 1'b0, "R8");
        chk("R8 pulse after origin strobe", int'(start_s), 1);
        tick(1'b0, 1'b0, "R6");
        chk("R8 pulse one cycle", int'(start_s), 0);
    endtask

    task automatic t_unreachable();
        ofs_s = 32'h0005_0000;
        tick(1'b0, 1'b1, "R5");
        cnt_s = 0;
        for (int i = 0; i < FRAME_S + 10; i++) tick(1'b1, 1'b0, "R10");
        ofs_s = 32'h0700_0000;
        for (int i = 0; i < FRAME_S; i++) tick(1'b1, 1'b0, "R10");
        chk("R10 out-of-range never fires", cnt_s, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_count();
        t_example();
        t_ignore_bits();
        t_full_frame();
        t_sync_priority();
        t_unreachable();
        tick(1'b0, 1'b0, "R6");
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule